// File: doc/BRIEF.md
# Pushbuffer Method Stream Decoder

This block turns a stream of 32-bit command words into single method writes. Each write carries a subchannel, a method address, a data value and a last flag. A word that arrives while no command is open is a header. A header names a starting method, a subchannel, a data count and one of four submission modes. The data words that follow are dispatched one at a time. The method address moves after each word according to the mode. An inline header carries its one data value inside itself.

Writes to method addresses below a host boundary go to a host-control port. All other writes go to the engine port of the addressed subchannel. Engine writes at or above the macro base are flagged. The open command is kept in registers, so a command may stretch across gaps in the input stream.

Input and outputs use valid/ready handshakes. The dispatch path is combinational from the input word to the output ports. A stalled output therefore holds the input word in place.

Top module: `pb_method_decoder`

## Requirements
- R1: A header word is any word accepted while the remaining count is zero. Its fields are: bits [12:0] method, bits [15:13] subchannel, bits [28:16] count or inline value, and bits [31:29] mode code. Mode codes are 1 incrementing, 3 non-incrementing, 4 inline and 5 increment-once. A non-inline header produces no output write.
- R2: In incrementing mode, the n-th data word (counting from 0) is written to the header method plus n, modulo 2^13.
- R3: In non-incrementing mode, every data word is written to the header method.
- R4: In increment-once mode, the first data word is written to the header method. Every later data word is written to the header method plus one.
- R5: An inline header (code 4) is dispatched at once to its own method and subchannel. The data value is bits [28:16] zero-extended to 32 bits, and no data words follow it.
- R6: After exactly count data words, the next word is decoded as a header. A non-inline header with count 0 opens no command.
- R7: The last flag on a data write is 1 only for the final data word of its command. Inline writes always carry last = 1.
- R8: A write with method below HOST_LIMIT (default 0x040) raises host_valid. Any other write raises only eng_valid[subchannel]. At most one valid is high in any cycle.
- R9: out_macro is 1 on an engine write whose method is at or above MACRO_BASE (0xE00). It is 0 on every other write.
- R10: A header with mode code 0, 2, 6 or 7 is consumed with no output write. The next word is again decoded as a header.
- R11: in_ready is low while the addressed output port is not ready. Header words that produce no write are always accepted. No write is lost or duplicated, and no output valid rises without in_valid.
- R12: A synchronous active-high reset clears the open command, so the first word after reset is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_word | input | 32 | Command or data word |
| host_valid | output | 1 | Host-control write valid |
| host_ready | input | 1 | Host-control port ready |
| eng_valid | output | 8 | Engine write valid, one bit per subchannel |
| eng_ready | input | 8 | Engine port ready, one bit per subchannel |
| out_sub | output | 3 | Subchannel of the write |
| out_meth | output | 13 | Method address of the write |
| out_data | output | 32 | Write data |
| out_last | output | 1 | Final write of the command |
| out_macro | output | 1 | Engine write into the macro range |

## Verification
The assertions check the routing invariants on every cycle:
- at most one port is valid at a time;
- the host port only sees addresses below the boundary, and the engine ports only see addresses at or above it;
- the macro flag never appears on a host write;
- a stalled port always drops in_ready;
- no write appears without an input word.

The address walk of each mode, the count bookkeeping, the last flag, inline values, ignored mode codes and the reset mid-command depend on word history. Only the bench scenarios show these. The bench compares every cycle against a model built from the requirements, under random backpressure and input gaps.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int WORD_W = 32;
    localparam int METH_W = 13;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = 13;
    localparam int CODE_W = WORD_W - METH_W - SUB_W - CNT_W;
    localparam int NUM_SUB = 1 << SUB_W;

    typedef enum logic [CODE_W-1:0] {
        MODE_IDLE   = 3'd0,
        MODE_INC    = 3'd1,
        MODE_NONINC = 3'd3,
        MODE_INLINE = 3'd4,
        MODE_INC1   = 3'd5
    } mode_e;

    // header layout, most significant field first
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
        logic [SUB_W-1:0]  sub;
        logic [METH_W-1:0] meth;
    } hdr_t;

    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [METH_W-1:0] meth;
        logic [WORD_W-1:0] data;
        logic              last;
    } mcall_t;

    function automatic logic opens_stream(input logic [CODE_W-1:0] code);
        return (code == MODE_INC) || (code == MODE_NONINC) || (code == MODE_INC1);
    endfunction

endpackage

// File: rtl/pbd_cmd_state.sv
module pbd_cmd_state
    import pbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    output logic              active,
    output logic              final_word,
    output logic [METH_W-1:0] cur_meth,
    output logic [SUB_W-1:0]  cur_sub
);
    mode_e             mode_q;
    logic [CNT_W-1:0]  rem_q;
    logic [METH_W-1:0] meth_q;
    logic [SUB_W-1:0]  sub_q;
    hdr_t              hdr;

    assign hdr        = hdr_t'(word);
    assign active     = (rem_q != '0);
    assign final_word = (rem_q == CNT_W'(1));
    assign cur_meth   = meth_q;
    assign cur_sub    = sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            rem_q  <= '0;
            meth_q <= '0;
            sub_q  <= '0;
        end else if (accept) begin
            if (active) begin
                rem_q <= rem_q - CNT_W'(1);
                case (mode_q)
                    MODE_INC: meth_q <= meth_q + METH_W'(1);
                    MODE_INC1: begin
                        meth_q <= meth_q + METH_W'(1);
                        mode_q <= MODE_NONINC;
                    end
                    default: ;
                endcase
            end else if (opens_stream(hdr.code)) begin
                mode_q <= mode_e'(hdr.code);
                rem_q  <= hdr.count;
                meth_q <= hdr.meth;
                sub_q  <= hdr.sub;
            end
        end
    end
endmodule

// File: rtl/pbd_issue.sv
module pbd_issue
    import pbd_pkg::*;
(
    input  logic              active,
    input  logic              final_word,
    input  logic [METH_W-1:0] cur_meth,
    input  logic [SUB_W-1:0]  cur_sub,
    input  logic [WORD_W-1:0] word,
    output logic              need,
    output mcall_t            call
);
    hdr_t hdr;
    assign hdr = hdr_t'(word);

    always_comb begin
        need = 1'b0;
        call = '0;
        if (active) begin
            need      = 1'b1;
            call.meth = cur_meth;
            call.sub  = cur_sub;
            call.data = word;
            call.last = final_word;
        end else if (hdr.code == MODE_INLINE) begin
            need      = 1'b1;
            call.meth = hdr.meth;
            call.sub  = hdr.sub;
            call.data = WORD_W'(hdr.count);
            call.last = 1'b1;
        end
    end
endmodule

// File: rtl/pbd_router.sv
module pbd_router
    import pbd_pkg::*;
#(
    parameter logic [METH_W-1:0] HOST_LIMIT = 13'h040,
    parameter logic [METH_W-1:0] MACRO_BASE = 13'hE00
) (
    input  logic               fire,
    input  mcall_t             call,
    input  logic               host_ready,
    input  logic [NUM_SUB-1:0] eng_ready,
    output logic               host_valid,
    output logic [NUM_SUB-1:0] eng_valid,
    output logic               sel_ready,
    output logic               macro
);
    logic to_host;
    assign to_host    = (call.meth < HOST_LIMIT);
    assign host_valid = fire && to_host;
    assign sel_ready  = to_host ? host_ready : eng_ready[call.sub];
    assign macro      = !to_host && (call.meth >= MACRO_BASE);

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_eng
        assign eng_valid[s] = fire && !to_host && (call.sub == SUB_W'(s));
    end
endmodule

// File: rtl/pb_method_decoder.sv
module pb_method_decoder
    import pbd_pkg::*;
#(
    parameter logic [METH_W-1:0] HOST_LIMIT = 13'h040,
    parameter logic [METH_W-1:0] MACRO_BASE = 13'hE00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               host_valid,
    input  logic               host_ready,
    output logic [NUM_SUB-1:0] eng_valid,
    input  logic [NUM_SUB-1:0] eng_ready,
    output logic [SUB_W-1:0]   out_sub,
    output logic [METH_W-1:0]  out_meth,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_last,
    output logic               out_macro
);
    logic              active, final_word, need, sel_ready;
    logic [METH_W-1:0] cur_meth;
    logic [SUB_W-1:0]  cur_sub;
    mcall_t            call;

    pbd_cmd_state u_state (
        .clk        (clk),
        .rst        (rst),
        .accept     (in_valid && in_ready),
        .word       (in_word),
        .active     (active),
        .final_word (final_word),
        .cur_meth   (cur_meth),
        .cur_sub    (cur_sub)
    );

    pbd_issue u_issue (
        .active     (active),
        .final_word (final_word),
        .cur_meth   (cur_meth),
        .cur_sub    (cur_sub),
        .word       (in_word),
        .need       (need),
        .call       (call)
    );

    pbd_router #(.HOST_LIMIT(HOST_LIMIT), .MACRO_BASE(MACRO_BASE)) u_route (
        .fire       (in_valid && need),
        .call       (call),
        .host_ready (host_ready),
        .eng_ready  (eng_ready),
        .host_valid (host_valid),
        .eng_valid  (eng_valid),
        .sel_ready  (sel_ready),
        .macro      (out_macro)
    );

    assign in_ready = need ? sel_ready : 1'b1;
    assign out_sub  = call.sub;
    assign out_meth = call.meth;
    assign out_data = call.data;
    assign out_last = call.last;
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
    import pbd_pkg::*;
#(
    parameter logic [METH_W-1:0] HOST_LIMIT = 13'h040
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               host_valid,
    input logic               host_ready,
    input logic [NUM_SUB-1:0] eng_valid,
    input logic [NUM_SUB-1:0] eng_ready,
    input logic [METH_W-1:0]  out_meth,
    input logic               out_macro
);
    assert_one_port_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({host_valid, eng_valid}));

    assert_host_range_R8: assert property (@(posedge clk) disable iff (rst)
        host_valid |-> (out_meth < HOST_LIMIT));

    assert_eng_range_R8: assert property (@(posedge clk) disable iff (rst)
        (|eng_valid) |-> (out_meth >= HOST_LIMIT));

    assert_no_macro_host_R9: assert property (@(posedge clk) disable iff (rst)
        host_valid |-> !out_macro);

    assert_host_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_ready) |-> !in_ready);

    assert_eng_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (|(eng_valid & ~eng_ready)) |-> !in_ready);

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        (host_valid || (|eng_valid)) |-> in_valid);
endmodule

bind pb_method_decoder pbd_checker #(.HOST_LIMIT(HOST_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .eng_valid  (eng_valid),
    .eng_ready  (eng_ready),
    .out_meth   (out_meth),
    .out_macro  (out_macro)
);

// File: tb/tb_pb_method_decoder.sv
`timescale 1ns/1ps
module tb_pb_method_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        host_valid;
    logic        host_ready = 1'b1;
    logic [7:0]  eng_valid;
    logic [7:0]  eng_ready = '1;
    logic [2:0]  out_sub;
    logic [12:0] out_meth;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_macro;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // bench model of the open command
    int          m_rem = 0;
    int          m_mode = 0;
    logic [12:0] m_meth = '0;
    logic [2:0]  m_sub = '0;
    string       force_tag = "";

    pb_method_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .host_valid(host_valid), .host_ready(host_ready), .eng_valid(eng_valid),
        .eng_ready(eng_ready), .out_sub(out_sub), .out_meth(out_meth), .out_data(out_data),
        .out_last(out_last), .out_macro(out_macro)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input int mode, input int cnt, input int sub,
                                        input int meth);
        return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
    endfunction

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = $urandom;
        #1;
        chk("R11", "host_valid idle", {31'b0, host_valid}, 32'd0);
        chk("R11", "eng_valid idle", {24'b0, eng_valid}, 32'd0);
    endtask

    task automatic send(input logic [31:0] w, input bit rand_ready);
        bit done = 0;
        while (!done) begin
            logic        e_disp, e_last, to_host, e_rdy;
            logic [12:0] e_meth;
            logic [2:0]  e_sub;
            logic [31:0] e_data;
            logic [7:0]  e_eng;
            string       tv, ta;
            int          code;
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = w;
            if (rand_ready) begin
                host_ready = ($urandom % 4) != 0;
                eng_ready  = 8'($urandom) | 8'($urandom);
            end else begin
                host_ready = 1'b1;
                eng_ready  = '1;
            end
            #1;
            code   = int'(w[31:29]);
            e_disp = 1'b0; e_last = 1'b0; e_meth = '0; e_sub = '0; e_data = '0;
            if (m_rem != 0) begin
                e_disp = 1'b1; e_meth = m_meth; e_sub = m_sub; e_data = w;
                e_last = (m_rem == 1);
                tv = "R6";
                ta = (m_mode == 1) ? "R2" : (m_mode == 3) ? "R3" : "R4";
            end else if (code == 4) begin
                e_disp = 1'b1; e_meth = w[12:0]; e_sub = w[15:13];
                e_data = {19'b0, w[28:16]}; e_last = 1'b1;
                tv = "R5"; ta = "R5";
            end else begin
                tv = (code == 1 || code == 3 || code == 5) ? "R1" : "R10";
                ta = tv;
            end
            if (force_tag != "") tv = force_tag;
            to_host = e_meth < 13'h040;
            e_eng   = (e_disp && !to_host) ? (8'd1 << e_sub) : 8'd0;
            e_rdy   = e_disp ? (to_host ? host_ready : eng_ready[e_sub]) : 1'b1;
            chk(tv, "host_valid", {31'b0, host_valid}, {31'b0, e_disp && to_host});
            chk("R8", "eng_valid", {24'b0, eng_valid}, {24'b0, e_eng});
            chk("R11", "in_ready", {31'b0, in_ready}, {31'b0, e_rdy});
            if (e_disp) begin
                chk(ta, "meth", {19'b0, out_meth}, {19'b0, e_meth});
                chk(ta, "sub", {29'b0, out_sub}, {29'b0, e_sub});
                chk(ta, "data", out_data, e_data);
                chk("R7", "last", {31'b0, out_last}, {31'b0, e_last});
                chk("R9", "macro", {31'b0, out_macro},
                    {31'b0, !to_host && (e_meth >= 13'hE00)});
            end
            if (e_rdy) begin
                done = 1;
                if (m_rem != 0) begin
                    m_rem--;
                    if (m_mode == 1) m_meth = m_meth + 13'd1;
                    if (m_mode == 5) begin m_meth = m_meth + 13'd1; m_mode = 3; end
                end else if (code == 1 || code == 3 || code == 5) begin
                    m_mode = code; m_rem = int'(w[28:16]);
                    m_meth = w[12:0]; m_sub = w[15:13];
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_rem = 0; m_mode = 0;
        #1;
        chk("R12", "in_ready after reset", {31'b0, in_ready}, 32'd1);
        chk("R12", "host_valid after reset", {31'b0, host_valid}, 32'd0);
        chk("R12", "eng_valid after reset", {24'b0, eng_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R2 incrementing burst to host addresses
        send(hdr(1, 3, 0, 'h10), 0);
        send(32'hA0, 0); send(32'hA1, 0); send(32'hA2, 0);
        // R3 non-incrementing across input gaps, engine subch 2
        send(hdr(3, 3, 2, 'h100), 0);
        send(32'hB0, 0); idle_cycle(); send(32'hB1, 1); idle_cycle(); send(32'hB2, 1);
        // R4 increment-once in macro range, R9
        send(hdr(5, 4, 5, 'hE00), 1);
        for (int i = 0; i < 4; i++) send(32'hC0 + i, 1);
        // R5 inline to host and engine
        send(hdr(4, 'h1AB, 1, 'h20), 1);
        send(hdr(4, 'h1FFF, 7, 'h1FFF), 1);
        // R6 count zero opens nothing
        send(hdr(1, 0, 3, 'h200), 0);
        send(hdr(4, 5, 3, 'h44), 0);
        // R10 unknown mode codes
        send(hdr(0, 2, 1, 'h300), 0);
        send(hdr(2, 2, 1, 'h300), 0);
        send(hdr(6, 2, 1, 'h300), 0);
        send(hdr(7, 2, 1, 'h300), 0);
        send(hdr(4, 9, 1, 'h300), 0);
        // R2 address wrap at the top of the method space
        send(hdr(1, 2, 6, 'h1FFF), 0);
        send(32'hD0, 0); send(32'hD1, 0);
        // R12 reset in the middle of a command
        send(hdr(1, 5, 4, 'h50), 0);
        send(32'hE0, 0);
        do_reset();
        force_tag = "R12";
        send(hdr(4, 'h77, 4, 'h30), 0);
        force_tag = "";
        // random stream with backpressure
        for (int n = 0; n < 1500; n++) begin
            int mode_pick, cnt, meth, sub;
            mode_pick = $urandom % 10;
            case (mode_pick)
                0, 1, 2: mode_pick = 1;
                3, 4:    mode_pick = 3;
                5, 6:    mode_pick = 5;
                7, 8:    mode_pick = 4;
                default: mode_pick = ($urandom % 2) ? 2 : 7;
            endcase
            cnt = $urandom % 6;
            if (mode_pick == 4) cnt = $urandom % 8192;
            case ($urandom % 3)
                0:       meth = $urandom % 'h40;
                1:       meth = 'h40 + ($urandom % ('hE00 - 'h40));
                default: meth = 'hE00 + ($urandom % 'h200);
            endcase
            sub = $urandom % 8;
            if (($urandom % 4) == 0) idle_cycle();
            send(hdr(mode_pick, cnt, sub, meth), 1);
            if (mode_pick == 1 || mode_pick == 3 || mode_pick == 5) begin
                for (int k = 0; k < cnt; k++) begin
                    if (($urandom % 5) == 0) idle_cycle();
                    send($urandom, 1);
                end
            end
        end
        idle_cycle();
        summary();
        $finish;
    end
endmodule